// File: doc/BRIEF.md
# Flash Array Program/Erase Engine

This block is the storage side behind a serial NOR flash command sequencer. It keeps the whole byte array in on-chip registers. It takes two kinds of request: single-byte program requests (address and data) and region erase requests (address and size kind). It also gives a registered byte read port. A program finishes in the clock that accepts it. An erase writes 0xFF into one byte per clock and holds `busy` high for the whole run.

Programming follows NOR rules. The new byte is ANDed into the cell, so bits can only be cleared. If a byte tries to raise a bit, a one-cycle warning is given. Capability flags can enable an overwrite mode that behaves like EEPROM. The engine itself gates erases on write-enable and on the capability flags. A rejected erase changes no cell and gives a one-cycle error pulse. Serial decoding, non-volatile backing and cell timing are the job of the surrounding logic.

The device holds `SECTOR_BYTES * SECTOR_COUNT` bytes. All sizes must be powers of two, with SMALL ≤ MID ≤ SECTOR. A typical configuration uses 4 KiB, 32 KiB and 64 KiB regions. The defaults are scaled down.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset, every array byte reads 0xFF, and `busy`, `errPulse` and `warnPulse` are 0.
- R2: `rdData` shows the byte at `rdAddr` one clock after `rdAddr` is applied.
- R3: In the default mode (CAP_FLAGS bit 8 clear), a program request accepted while idle stores old AND new at `progAddr` in the accepting clock. It does this whatever the level of `writeEnable`.
- R4: When CAP_FLAGS bit 8 is set, a program stores `progData` directly and never raises `warnPulse`.
- R5: In the default mode, a program whose data has a 1 where the stored byte has a 0 raises `warnPulse` for exactly the one clock after acceptance. The stored value is still the AND result.
- R6: `eraseKind` selects the region size: 0 selects SMALL_BYTES, 1 selects MID_BYTES, 2 selects SECTOR_BYTES and 3 selects the whole device. The start address is aligned down to the region size. Every byte of that region becomes 0xFF, and bytes outside it keep their values.
- R7: After an erase is accepted, `busy` is high for exactly as many clocks as the region has bytes. It falls in the clock after the last byte is written.
- R8: An erase request with `writeEnable` low is ignored. `errPulse` is high for the one clock after the request.
- R9: CAP_FLAGS bit 0 enables kind 0 and bit 1 enables kind 1. Kinds 2 and 3 are always enabled. A request for a disabled kind is ignored, and `errPulse` is high for one clock.
- R10: While `busy` is high, program and erase requests are ignored and raise no error.
- R11: A program request in the same cycle as an erase request is dropped. The erase request is handled as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; refills the array with 0xFF |
| progValid | input | 1 | Program request strobe |
| progAddr | input | ADDR_W | Program byte address |
| progData | input | 8 | Program byte value |
| eraseValid | input | 1 | Erase request strobe |
| eraseAddr | input | ADDR_W | Any address inside the region to erase |
| eraseKind | input | 2 | Region size select (0 small, 1 mid, 2 sector, 3 whole) |
| writeEnable | input | 1 | Erase permission level |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Registered read data |
| busy | output | 1 | Erase in progress |
| errPulse | output | 1 | One-clock pulse for a rejected erase |
| warnPulse | output | 1 | One-clock pulse when a program tries to raise a bit |

## Verification
- A program result can be read through `rdAddr` from the next clock. `rdData` then lags `rdAddr` by one more edge.
- `warnPulse` and `errPulse` are due on the edge that follows the accepting edge.
- An erase keeps `busy` high for one edge per byte in the region.
- The bench drives inputs on falling edges and samples outputs on the next falling edge, one edge after the stimulus. It counts `busy` samples edge by edge until the erase ends and compares the count with the region size. It then reads back the whole array and compares it with a model built from the requirements.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {
    KIND_SMALL  = 2'd0,
    KIND_MID    = 2'd1,
    KIND_SECTOR = 2'd2,
    KIND_WHOLE  = 2'd3
  } eraseKind_e;

  // strobes from control to the array datapath
  typedef struct packed {
    logic progWr;
    logic fillWr;
  } arrCmd_t;

  localparam int CAP_SMALL_BIT = 0;
  localparam int CAP_MID_BIT   = 1;
  localparam int CAP_ONES_BIT  = 8;
endpackage

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SMALL_BYTES = 64,
  parameter int MID_BYTES = 256,
  parameter int SECTOR_BYTES = 512,
  parameter int DEPTH = 2048,
  parameter logic [15:0] CAP_FLAGS = 16'h0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progValid,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic              eraseValid,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic [1:0]        eraseKind,
  input  logic              writeEnable,
  output arrCmd_t           cmd,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              busy,
  output logic              errPulse
);
  localparam logic [ADDR_W-1:0] SMALL_MASK  = ADDR_W'(SMALL_BYTES - 1);
  localparam logic [ADDR_W-1:0] MID_MASK    = ADDR_W'(MID_BYTES - 1);
  localparam logic [ADDR_W-1:0] SECTOR_MASK = ADDR_W'(SECTOR_BYTES - 1);
  localparam logic [ADDR_W-1:0] WHOLE_MASK  = ADDR_W'(DEPTH - 1);
  localparam bit CAN_SMALL = CAP_FLAGS[CAP_SMALL_BIT];
  localparam bit CAN_MID   = CAP_FLAGS[CAP_MID_BIT];

  logic              busyQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] endQ;
  logic              errQ;
  logic [ADDR_W-1:0] regionMask;
  logic              kindOk;
  logic              eraseReq;
  logic              eraseGo;
  logic              eraseBad;

  always_comb begin
    unique case (eraseKind_e'(eraseKind))
      KIND_SMALL:  begin regionMask = SMALL_MASK;  kindOk = CAN_SMALL; end
      KIND_MID:    begin regionMask = MID_MASK;    kindOk = CAN_MID;   end
      KIND_SECTOR: begin regionMask = SECTOR_MASK; kindOk = 1'b1;      end
      default:     begin regionMask = WHOLE_MASK;  kindOk = 1'b1;      end
    endcase
  end

  assign eraseReq = eraseValid && !busyQ;
  assign eraseGo  = eraseReq && writeEnable && kindOk;
  assign eraseBad = eraseReq && !(writeEnable && kindOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      ptrQ  <= '0;
      endQ  <= '0;
      errQ  <= 1'b0;
    end else begin
      errQ <= eraseBad;
      if (eraseGo) begin
        busyQ <= 1'b1;
        ptrQ  <= eraseAddr & ~regionMask;
        endQ  <= eraseAddr | regionMask;
      end else if (busyQ) begin
        if (ptrQ == endQ) busyQ <= 1'b0;
        else              ptrQ  <= ptrQ + ADDR_W'(1);
      end
    end
  end

  assign cmd.fillWr = busyQ;
  assign cmd.progWr = progValid && !busyQ && !eraseValid;
  assign wrAddr     = busyQ ? ptrQ : progAddr;
  assign busy       = busyQ;
  assign errPulse   = errQ;

  // R8: erase without write permission is refused with an error pulse
  a_r8_we_low_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (eraseValid && !busy && !writeEnable) |=> (errPulse && !busy));
  // R10: requests during a run never produce an error
  a_r10_no_err_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !errPulse);
  // R7: fill pointer never leaves the region
  a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (ptrQ <= endQ));
  // R7: busy holds until the last byte
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ptrQ != endQ) |=> busy);
endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH = 2048,
  parameter bit WRITE_ONES = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  arrCmd_t           cmd,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              warnPulse
);
  logic [7:0] mem [DEPTH];
  logic [7:0] oldByte;
  logic [7:0] newByte;
  logic       raisesBit;
  logic       warnQ;
  logic [7:0] rdQ;

  assign oldByte   = mem[wrAddr];
  assign raisesBit = |(wrData & ~oldByte);

  generate
    if (WRITE_ONES) begin : g_direct
      assign newByte = wrData;
    end else begin : g_nor
      assign newByte = oldByte & wrData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      rdQ   <= 8'h00;
      warnQ <= 1'b0;
    end else begin
      rdQ   <= mem[rdAddr];
      warnQ <= cmd.progWr && !WRITE_ONES && raisesBit;
      if (cmd.fillWr)      mem[wrAddr] <= 8'hFF;
      else if (cmd.progWr) mem[wrAddr] <= newByte;
    end
  end

  assign rdData    = rdQ;
  assign warnPulse = warnQ;

  // R6: every filled byte reads erased afterwards
  a_r6_fill_ff: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fillWr |=> (mem[$past(wrAddr)] == 8'hFF));
  // R5: warning only follows an accepted program
  a_r5_warn_src: assert property (@(posedge clk) disable iff (!rstN)
    warnPulse |-> $past(cmd.progWr));

  generate
    if (!WRITE_ONES) begin : g_chk_nor
      // R3: default-mode program can only clear bits
      a_r3_only_clears: assert property (@(posedge clk) disable iff (!rstN)
        cmd.progWr |=> ((mem[$past(wrAddr)] & ~$past(oldByte)) == 8'h00));
    end else begin : g_chk_ones
      // R4: overwrite mode never warns
      a_r4_no_warn: assert property (@(posedge clk) disable iff (!rstN)
        !warnPulse);
    end
  endgenerate
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int SMALL_BYTES = 64,
  parameter int MID_BYTES = 256,
  parameter int SECTOR_BYTES = 512,
  parameter int SECTOR_COUNT = 4,
  parameter logic [15:0] CAP_FLAGS = 16'h0001,
  localparam int DEPTH = SECTOR_BYTES * SECTOR_COUNT,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progValid,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        progData,
  input  logic              eraseValid,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic [1:0]        eraseKind,
  input  logic              writeEnable,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              errPulse,
  output logic              warnPulse
);
  localparam bit WRITE_ONES = CAP_FLAGS[CAP_ONES_BIT];

  arrCmd_t           cmd;
  logic [ADDR_W-1:0] wrAddr;

  flash_pe_ctrl #(
    .ADDR_W(ADDR_W), .SMALL_BYTES(SMALL_BYTES), .MID_BYTES(MID_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .DEPTH(DEPTH), .CAP_FLAGS(CAP_FLAGS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .progValid(progValid), .progAddr(progAddr),
    .eraseValid(eraseValid), .eraseAddr(eraseAddr), .eraseKind(eraseKind),
    .writeEnable(writeEnable), .cmd(cmd), .wrAddr(wrAddr), .busy(busy),
    .errPulse(errPulse)
  );

  flash_pe_array #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WRITE_ONES(WRITE_ONES)
  ) u_array (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrAddr(wrAddr), .wrData(progData),
    .rdAddr(rdAddr), .rdData(rdData), .warnPulse(warnPulse)
  );
endmodule

// File: tb/tb_flash_pe_engine.sv
`timescale 1ns/1ps
module tb_flash_pe_engine;
  localparam int N = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progValid = 1'b0, eraseValid = 1'b0, writeEnable = 1'b0;
  logic [AW-1:0] progAddr = '0, eraseAddr = '0, rdAddr = '0;
  logic [7:0] progData = '0;
  logic [1:0] eraseKind = '0;
  logic [7:0] rdA, rdB;
  logic busyA, busyB, errA, errB, warnA, warnB;

  int checks = 0;
  int errors = 0;
  logic [7:0] mA [N];
  logic [7:0] mB [N];

  always #2.5 clk = ~clk;

  // default NOR mode, small erase only
  flash_pe_engine #(.SMALL_BYTES(8), .MID_BYTES(32), .SECTOR_BYTES(64),
    .SECTOR_COUNT(4), .CAP_FLAGS(16'h0001)) dut (
    .clk(clk), .rstN(rstN), .progValid(progValid), .progAddr(progAddr),
    .progData(progData), .eraseValid(eraseValid), .eraseAddr(eraseAddr),
    .eraseKind(eraseKind), .writeEnable(writeEnable), .rdAddr(rdAddr),
    .rdData(rdA), .busy(busyA), .errPulse(errA), .warnPulse(warnA));

  // overwrite mode, all erase sizes
  flash_pe_engine #(.SMALL_BYTES(8), .MID_BYTES(32), .SECTOR_BYTES(64),
    .SECTOR_COUNT(4), .CAP_FLAGS(16'h0103)) dutOnes (
    .clk(clk), .rstN(rstN), .progValid(progValid), .progAddr(progAddr),
    .progData(progData), .eraseValid(eraseValid), .eraseAddr(eraseAddr),
    .eraseKind(eraseKind), .writeEnable(writeEnable), .rdAddr(rdAddr),
    .rdData(rdB), .busy(busyB), .errPulse(errB), .warnPulse(warnB));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int regionSize(input int k);
    case (k)
      0: return 8;
      1: return 32;
      2: return 64;
      default: return N;
    endcase
  endfunction

  task automatic compareAll(input string req);
    for (int a = 0; a < N; a++) begin
      rdAddr = AW'(a);
      @(negedge clk);
      check(rdA == mA[a], {req, " R2 nor-array"}, rdA, mA[a]);
      check(rdB == mB[a], {req, " R2 ones-array"}, rdB, mB[a]);
    end
  endtask

  task automatic doProg(input int a, input int d);
    logic expWarn;
    expWarn = |(8'(d) & ~mA[a]);
    progAddr = AW'(a); progData = 8'(d); progValid = 1'b1;
    @(negedge clk);
    progValid = 1'b0;
    check(warnA == expWarn, "R5 warn nor", warnA, expWarn);
    check(warnB == 1'b0, "R4 warn ones", warnB, 0);
    mA[a] = mA[a] & 8'(d);
    mB[a] = 8'(d);
    @(negedge clk);
    check(warnA == 1'b0, "R5 warn single cycle", warnA, 0);
  endtask

  // simProg: program request in the same cycle (R11); intrude: requests while busy (R10)
  task automatic doErase(input int a, input int k, input bit we, input bit intrude,
                         input bit simProg, input int pa);
    int cntA, cntB, sz, base;
    bit okA, okB;
    sz = regionSize(k);
    okA = we && (k != 1);
    okB = we;
    eraseAddr = AW'(a); eraseKind = 2'(k); writeEnable = we; eraseValid = 1'b1;
    if (simProg) begin progAddr = AW'(pa); progData = 8'h00; progValid = 1'b1; end
    @(negedge clk);
    eraseValid = 1'b0; progValid = 1'b0;
    check(errA == !okA, "R8/R9 err nor", errA, !okA);
    check(errB == !okB, "R8/R9 err ones", errB, !okB);
    cntA = 0; cntB = 0;
    for (int i = 0; i < 2000; i++) begin
      if (busyA) cntA++;
      if (busyB) cntB++;
      if (i > 0) begin
        check(errA == 1'b0 && errB == 1'b0, "R10 no err while busy", {errA, errB}, 0);
      end
      if (!busyA && !busyB) break;
      if (intrude && i == 1) begin
        progAddr = 8'h10; progData = 8'h00; progValid = 1'b1;
        eraseAddr = 8'h00; eraseKind = 2'd3; writeEnable = 1'b1; eraseValid = 1'b1;
      end
      if (intrude && i == 3) begin progValid = 1'b0; eraseValid = 1'b0; end
      @(negedge clk);
    end
    check(cntA == (okA ? sz : 0), "R7 busy cycles nor", cntA, okA ? sz : 0);
    check(cntB == (okB ? sz : 0), "R7 busy cycles ones", cntB, okB ? sz : 0);
    base = a & ~(sz - 1);
    for (int j = base; j < base + sz; j++) begin
      if (okA) mA[j] = 8'hFF;
      if (okB) mB[j] = 8'hFF;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mA[i] = 8'hFF; mB[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(busyA == 0 && busyB == 0, "R1 busy after reset", {busyA, busyB}, 0);
    check(errA == 0 && errB == 0, "R1 err after reset", {errA, errB}, 0);
    check(warnA == 0 && warnB == 0, "R1 warn after reset", {warnA, warnB}, 0);
    compareAll("R1 erased array");

    // R3 R4 R5 program behaviour, writeEnable low on purpose
    writeEnable = 1'b0;
    doProg(5, 8'h3C);
    doProg(5, 8'hC3);
    for (int i = 0; i < 40; i++) doProg((i * 7 + 3) % N, (i * 37 + 11) % 256);
    for (int i = 0; i < 20; i++) doProg((i * 13 + 1) % N, (i * 91) % 256);
    compareAll("R3 R4 programmed");

    // R6 R7 unaligned small erase
    doErase(8'h0D, 0, 1'b1, 1'b0, 1'b0, 0);
    compareAll("R6 small erase");
    // R9 mid erase unsupported on nor instance
    doErase(8'h45, 1, 1'b1, 1'b0, 1'b0, 0);
    compareAll("R9 mid erase");
    // R8 erase without permission
    doErase(8'hC7, 2, 1'b0, 1'b0, 1'b0, 0);
    compareAll("R8 we low");
    // R10 requests while busy are ignored
    doErase(8'h83, 2, 1'b1, 1'b1, 1'b0, 0);
    compareAll("R10 busy ignore");
    // R11 simultaneous program and erase
    doErase(8'h30, 0, 1'b1, 1'b0, 1'b1, 8'h20);
    compareAll("R11 erase wins");
    // R6 R7 whole-device erase
    for (int i = 0; i < 16; i++) doProg(i * 16 + 2, 8'h00);
    doErase(8'h77, 3, 1'b1, 1'b0, 1'b0, 0);
    compareAll("R6 whole erase");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule